// File: doc/BRIEF.md
# Descriptor-Table DMA Engine for a Storage Channel

This block moves data between a drive-side word stream and system memory on behalf of a host. The host reaches it through an eight-byte register window. In that window it loads a 32-bit pointer to a table of transfer descriptors, chooses a direction and sets the start bit. The engine then reads descriptors from memory one at a time. Each descriptor names a memory buffer and a byte count. For every word the engine either writes a drive word into the buffer or reads a buffer word and hands it to the drive.

A transfer can end in four ways, and the status byte tells them apart. The table and the drive may run out together. The table may run out before the drive has finished, or the drive may finish while descriptor space remains. A memory access may also fault. The host can abort at any time by writing zero to the command byte. The interrupt line follows the status interrupt bit, and the host clears that bit by writing a one to it.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset the command byte, the status byte and all four pointer bytes read 0x00, `irq` is low and `mem_req` is low.
- R2: Window offsets: 0x0 is the command byte (bit 0 = run, bit 3 = direction, where 1 means drive to memory), 0x2 is the status byte, and 0x4 to 0x7 hold the table pointer, least significant byte first. Every other offset reads 0x00.
- R3: Each descriptor is fetched as two 32-bit reads: first at the table cursor (the buffer address), then at cursor+4 (bits 15:0 hold the byte count, bit 31 is the last-entry flag). The next descriptor is fetched at cursor+8.
- R4: With direction 1, each drive word is written to memory at the descriptor's buffer address, and the address advances by 4 for each word. One word is moved per 4 bytes of count.
- R5: With direction 0, buffer words are read from memory in address order and presented to the drive in that order.
- R6: A byte count of zero stands for 65536 bytes, which is 16384 words.
- R7: When the last descriptor and the drive finish together, the status reads 0x04 (active clear, interrupt set) and `irq` is high.
- R8: When the last descriptor is used up before `dev_done`, the engine stops with status 0x00 and issues no further memory requests.
- R9: When `dev_done` comes while descriptor space remains, the status reads 0x05 (active and interrupt set). A following write of 0x00 to the command byte leaves 0x04.
- R10: Writing 0x00 to the command byte during a transfer clears active at once. No memory request follows, and the interrupt bit does not change.
- R11: Writing status with bit 2 set clears the interrupt bit and drops `irq`. Writing status with bit 2 clear leaves it unchanged.
- R12: A memory response with `mem_err` set ends the transfer with status 0x06 (error and interrupt set, active clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 3 | Register window offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational from reg_addr) |
| irq | output | 1 | Interrupt, equal to the status interrupt bit |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Memory acknowledge, same cycle as the read data |
| mem_err | input | 1 | Fault flag, valid with mem_ack |
| mem_rdata | input | 32 | Memory read word |
| dev_rx_valid | input | 1 | Drive has a word for memory |
| dev_rx_data | input | 32 | Word from the drive |
| dev_rx_ready | output | 1 | Drive word taken |
| dev_tx_valid | output | 1 | Word for the drive is valid |
| dev_tx_data | output | 32 | Word for the drive |
| dev_tx_ready | input | 1 | Drive takes the word |
| dev_done | input | 1 | Drive has finished its transfer (level, no later than the cycle after its last word) |

## Verification
The bench goes after the three ways a transfer can end: exact match, a table that is too short and a table that is too long, including a drive that finishes exactly on a descriptor boundary. An engine that checks end-of-table and drive-done in the wrong order would report 0x05 or 0x00 where 0x04 is due, or would fetch one descriptor too many. A zero byte count has to run for 16384 words; a design that took it literally would finish at once with status 0x00. Aborts mid-stream and aborts from the too-long state must clear only active. A memory fault must stop the engine at once, not after one more buffer write.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DESCA = 3'd1,
        S_DESCB = 3'd2,
        S_XFER  = 3'd3,
        S_PUSH  = 3'd4,
        S_HOLD  = 3'd5
    } dma_state_e;
endpackage

// File: rtl/prd_dma_ptr_regs.sv
module prd_dma_ptr_regs #(
    parameter int PTR_W = 32,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [PTR_W-1:0]  ptr
);
    localparam int NBYTES = PTR_W / 8;
    localparam logic [REG_AW-1:0] BASE = REG_AW'(4);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] byte_d, byte_q;
        always_comb begin
            byte_d = byte_q;
            if (wr && addr == BASE + REG_AW'(b)) byte_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end
        assign ptr[8*b +: 8] = byte_q;
    end
endmodule

// File: rtl/prd_dma_core.sv
module prd_dma_core
    import prd_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_run,
    input  logic              cmd_dir,
    input  logic              sts_wr,
    input  logic              sts_clr_irq,
    input  logic              sts_clr_err,
    input  logic [ADDR_W-1:0] tbl_ptr,
    output logic              run_o,
    output logic              dir_o,
    output logic              active_o,
    output logic              err_o,
    output logic              irq_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [DATA_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready,
    input  logic              dev_done
);
    localparam int WB     = DATA_W / 8;
    localparam int WB_LG  = $clog2(WB);
    localparam int WCNT_W = CNT_W - WB_LG + 1;
    localparam logic [WCNT_W-1:0] WMAX = WCNT_W'(1) << (CNT_W - WB_LG);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WB);

    typedef struct packed {
        dma_state_e        state;
        logic              run;
        logic              dir;
        logic              active;
        logic              err;
        logic              irq;
        logic              eot;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] baddr;
        logic [WCNT_W-1:0] words;
        logic [DATA_W-1:0] hold;
    } core_t;

    core_t q, d;
    logic  unused_bits;
    assign unused_bits = ^{mem_rdata[DATA_W-2:CNT_W]};

    always_comb begin
        d            = q;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        dev_rx_ready = 1'b0;
        dev_tx_valid = 1'b0;
        dev_tx_data  = q.hold;

        if (sts_wr && sts_clr_irq) d.irq = 1'b0;
        if (sts_wr && sts_clr_err) d.err = 1'b0;

        case (q.state)
            S_DESCA: begin
                mem_req  = 1'b1;
                mem_addr = q.cur;
                if (mem_ack) begin
                    d.baddr = mem_rdata[ADDR_W-1:0];
                    d.state = S_DESCB;
                end
            end
            S_DESCB: begin
                mem_req  = 1'b1;
                mem_addr = q.cur + STEP;
                if (mem_ack) begin
                    d.words = (mem_rdata[CNT_W-1:0] == '0) ? WMAX
                            : WCNT_W'(mem_rdata[CNT_W-1:WB_LG]);
                    d.eot   = mem_rdata[DATA_W-1];
                    d.cur   = q.cur + 2 * STEP;
                    d.state = S_XFER;
                end
            end
            S_XFER: begin
                if (q.words == '0) begin
                    if (q.eot) begin
                        d.active = 1'b0;
                        d.state  = S_IDLE;
                        if (dev_done) d.irq = 1'b1;
                    end else if (dev_done) begin
                        d.irq   = 1'b1;
                        d.state = S_HOLD;
                    end else begin
                        d.state = S_DESCA;
                    end
                end else if (dev_done) begin
                    d.irq   = 1'b1;
                    d.state = S_HOLD;
                end else if (q.dir) begin
                    mem_req   = dev_rx_valid;
                    mem_we    = 1'b1;
                    mem_addr  = q.baddr;
                    mem_wdata = dev_rx_data;
                    if (dev_rx_valid && mem_ack && !mem_err) begin
                        dev_rx_ready = 1'b1;
                        d.baddr      = q.baddr + STEP;
                        d.words      = q.words - 1'b1;
                    end
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = q.baddr;
                    if (mem_ack && !mem_err) begin
                        d.hold  = mem_rdata;
                        d.state = S_PUSH;
                    end
                end
            end
            S_PUSH: begin
                dev_tx_valid = 1'b1;
                if (dev_tx_ready) begin
                    d.baddr = q.baddr + STEP;
                    d.words = q.words - 1'b1;
                    d.state = S_XFER;
                end
            end
            default: ;
        endcase

        if (mem_req && mem_ack && mem_err) begin
            d.err    = 1'b1;
            d.irq    = 1'b1;
            d.active = 1'b0;
            d.state  = S_IDLE;
        end

        if (cmd_wr) begin
            d.run = cmd_run;
            if (!cmd_run) begin
                d.active = 1'b0;
                d.state  = S_IDLE;
            end else if (!q.active) begin
                d.dir    = cmd_dir;
                d.active = 1'b1;
                d.cur    = tbl_ptr;
                d.state  = S_DESCA;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign run_o    = q.run;
    assign dir_o    = q.dir;
    assign active_o = q.active;
    assign err_o    = q.err;
    assign irq_o    = q.irq;

    // R8 and R10: no memory traffic without an active transfer
    p_req_needs_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> q.active);

    // R10: abort clears active on the next cycle
    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !cmd_run |=> !q.active);

    // R12: a faulting response stops the engine with error and interrupt
    p_fault_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err && !cmd_wr |=> !q.active && q.err && q.irq);

    // R11: clearing the interrupt while no event can occur drops it
    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr && sts_clr_irq && (q.state == S_IDLE || q.state == S_HOLD) |=> !q.irq);
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [DATA_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready,
    input  logic              dev_done
);
    localparam logic [REG_AW-1:0] OFS_CMD = REG_AW'(0);
    localparam logic [REG_AW-1:0] OFS_STS = REG_AW'(2);

    logic [ADDR_W-1:0] tbl_ptr;
    logic run, dir, active, err, irq_q;

    prd_dma_ptr_regs #(.PTR_W(ADDR_W), .REG_AW(REG_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .ptr(tbl_ptr)
    );

    prd_dma_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(reg_wr && reg_addr == OFS_CMD),
        .cmd_run(reg_wdata[0]), .cmd_dir(reg_wdata[3]),
        .sts_wr(reg_wr && reg_addr == OFS_STS),
        .sts_clr_irq(reg_wdata[2]), .sts_clr_err(reg_wdata[1]),
        .tbl_ptr(tbl_ptr),
        .run_o(run), .dir_o(dir), .active_o(active), .err_o(err), .irq_o(irq_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
        .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
        .dev_done(dev_done)
    );

    assign irq = irq_q;

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == OFS_CMD)      reg_rdata = {4'b0, dir, 2'b0, run};
        else if (reg_addr == OFS_STS) reg_rdata = {5'b0, irq_q, err, active};
        else if (reg_addr[REG_AW-1])  reg_rdata = tbl_ptr[8*reg_addr[1:0] +: 8];
    end
endmodule

// File: tb/prd_dma_engine_tb.sv
`timescale 1ns/1ps
module prd_dma_engine_tb;
    localparam logic [31:0] TBL = 32'h0000_1000;
    localparam logic [31:0] BUF = 32'h0001_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic dev_rx_valid, dev_rx_ready, dev_tx_valid, dev_tx_ready, dev_done;
    logic [31:0] dev_rx_data, dev_tx_data;

    int errors = 0, checks = 0;
    logic [31:0] tbl [16];
    logic [31:0] fault_addr = 32'hFFFF_FFFF;
    bit mem_en = 1'b1, dev_en = 1'b1, dev_stall = 1'b0, run_dir = 1'b0, dev_clr = 1'b0;
    int dev_n = 0, dev_cnt = 0;
    logic [31:0] wr_a[$], wr_d[$], rd_a[$], tx_d[$];

    function automatic logic [31:0] rd_pat(logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction
    function automatic logic [31:0] dev_pat(int i);
        return 32'hC0DE_0000 + 32'(i * 3);
    endfunction

    assign mem_ack = mem_req && mem_en;
    assign mem_err = (mem_addr == fault_addr);
    assign mem_rdata = (mem_addr >= TBL && mem_addr < TBL + 64) ? tbl[mem_addr[5:2]] : rd_pat(mem_addr);
    assign dev_done = (dev_cnt == dev_n);
    assign dev_rx_valid = run_dir && (dev_cnt < dev_n) && dev_en && !dev_stall;
    assign dev_rx_data = dev_pat(dev_cnt);
    assign dev_tx_ready = (dev_cnt < dev_n) && dev_en && !dev_stall;

    always @(negedge clk) begin
        mem_en <= ($urandom % 4) != 0;
        dev_en <= ($urandom % 4) != 0;
    end

    always @(posedge clk) begin
        if (dev_clr) dev_cnt <= 0;
        else if ((dev_rx_valid && dev_rx_ready) || (dev_tx_valid && dev_tx_ready)) begin
            dev_cnt <= dev_cnt + 1;
            if (dev_tx_valid) tx_d.push_back(dev_tx_data);
        end
        if (mem_req && mem_ack && !mem_err) begin
            if (mem_we) begin wr_a.push_back(mem_addr); wr_d.push_back(mem_wdata); end
            else rd_a.push_back(mem_addr);
        end
    end

    prd_dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .dev_rx_valid(dev_rx_valid),
        .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready), .dev_done(dev_done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_end(input string tag);
        logic [7:0] s;
        int t;
        t = 0;
        do begin rreg(3'd2, s); t++; end while (s[0] && !s[2] && t < 60000);
        check(t < 60000, {tag, " watchdog"}, 32'(t), 32'd0);
    endtask

    task automatic prepare(input int nd, input int cw[4], input int n, input bit dir);
        for (int i = 0; i < nd; i++) begin
            tbl[2*i]   = BUF + 32'(i) * 32'h1000;
            tbl[2*i+1] = 32'(cw[i] * 4) | ((i == nd - 1) ? 32'h8000_0000 : 32'h0);
        end
        wreg(3'd2, 8'h06);
        wreg(3'd4, TBL[7:0]);   wreg(3'd5, TBL[15:8]);
        wreg(3'd6, TBL[23:16]); wreg(3'd7, TBL[31:24]);
        @(negedge clk);
        wr_a.delete(); wr_d.delete(); rd_a.delete(); tx_d.delete();
        run_dir = dir; dev_n = n; dev_clr = 1'b1;
        @(negedge clk);
        dev_clr = 1'b0;
    endtask

    task automatic run_case(input bit dir, input int nd, input int cw[4], input int n, input string tag);
        int tot, moved, fetched, acc, k, nfr;
        logic [7:0] s, exps;
        logic [31:0] ea[$];
        prepare(nd, cw, n, dir);
        wreg(3'd0, dir ? 8'h09 : 8'h01);
        wait_end(tag);
        tot = 0; fetched = 0; acc = 0;
        for (int i = 0; i < nd; i++) tot += cw[i];
        moved = (tot < n) ? tot : n;
        for (int i = 0; i < nd; i++) begin
            if (fetched == i && (acc < n || i == 0)) begin
                fetched++;
                acc += cw[i];
            end
        end
        for (int i = 0; i < nd; i++)
            for (int j = 0; j < cw[i]; j++) ea.push_back(BUF + 32'(i) * 32'h1000 + 32'(4 * j));
        exps = (tot == n) ? 8'h04 : (tot < n) ? 8'h00 : 8'h05;
        rreg(3'd2, s);
        check(s == exps, {tag, " R7/R8/R9 end status"}, 32'(s), 32'(exps));
        check(irq == exps[2], {tag, " R7 irq pin"}, 32'(irq), 32'(exps[2]));
        nfr = 0;
        foreach (rd_a[i]) if (rd_a[i] >= TBL && rd_a[i] < TBL + 64) begin
            check(rd_a[i] == TBL + 32'(4 * nfr), {tag, " R3 fetch addr"}, rd_a[i], TBL + 32'(4 * nfr));
            nfr++;
        end
        check(nfr == 2 * fetched, {tag, " R3 fetch count"}, 32'(nfr), 32'(2 * fetched));
        if (dir) begin
            check(wr_a.size() == moved, {tag, " R4 write count"}, 32'(wr_a.size()), 32'(moved));
            k = 0;
            foreach (wr_a[i]) if (i < moved) begin
                check(wr_a[i] == ea[i] && wr_d[i] == dev_pat(i), {tag, " R4 write word"}, wr_a[i], ea[i]);
                k++;
            end
        end else begin
            check(tx_d.size() == moved, {tag, " R5 drive word count"}, 32'(tx_d.size()), 32'(moved));
            foreach (tx_d[i]) if (i < moved)
                check(tx_d[i] == rd_pat(ea[i]), {tag, " R5 drive word"}, tx_d[i], rd_pat(ea[i]));
        end
        if (exps == 8'h05) begin
            wreg(3'd0, 8'h00);
            rreg(3'd2, s);
            check(s == 8'h04, {tag, " R9 abort after long table"}, 32'(s), 32'h04);
        end
    endtask

    initial begin : main
        logic [7:0] v;
        int cw[4];
        int mreq;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rreg(3'd0, v); check(v == 8'h00, "R1 cmd reset", 32'(v), 0);
        rreg(3'd2, v); check(v == 8'h00, "R1 status reset", 32'(v), 0);
        for (int i = 4; i < 8; i++) begin
            rreg(3'(i), v); check(v == 8'h00, "R1 ptr reset", 32'(v), 0);
        end
        check(irq == 1'b0 && mem_req == 1'b0, "R1 irq/mem_req reset", {30'b0, irq, mem_req}, 0);

        wreg(3'd4, 8'h78); wreg(3'd5, 8'h56); wreg(3'd6, 8'h34); wreg(3'd7, 8'h12);
        for (int i = 0; i < 4; i++) begin
            rreg(3'(4 + i), v);
            check(v == 8'(32'h12345678 >> (8 * i)), "R2 ptr byte", 32'(v), 32'(8'(32'h12345678 >> (8 * i))));
        end
        rreg(3'd1, v); check(v == 8'h00, "R2 unmapped offset", 32'(v), 0);
        rreg(3'd3, v); check(v == 8'h00, "R2 unmapped offset", 32'(v), 0);

        cw = '{3, 2, 0, 0}; run_case(1'b1, 2, cw, 5, "exact d1");
        rreg(3'd0, v); check(v[3] == 1'b1, "R2 direction bit readback", 32'(v), 32'h09);
        wreg(3'd2, 8'h00); rreg(3'd2, v);
        check(v == 8'h04 && irq, "R11 write 0 keeps irq", 32'(v), 32'h04);
        wreg(3'd2, 8'h04); rreg(3'd2, v);
        check(v == 8'h00 && !irq, "R11 write 1 clears irq", 32'(v), 32'h00);
        cw = '{2, 2, 0, 0}; run_case(1'b0, 2, cw, 4, "exact d0");
        cw = '{2, 1, 0, 0}; run_case(1'b1, 2, cw, 6, "short R8");
        repeat (10) @(negedge clk);
        check(mem_req == 1'b0, "R8 no request after short end", 32'(mem_req), 0);
        cw = '{2, 3, 4, 0}; run_case(1'b0, 3, cw, 2, "long boundary R9");
        cw = '{4, 4, 0, 0}; run_case(1'b1, 2, cw, 5, "long mid R9");

        for (int r = 0; r < 6; r++) begin
            int nd, tot, n;
            nd = 1 + int'($urandom % 3); tot = 0;
            for (int i = 0; i < 4; i++) begin cw[i] = 1 + int'($urandom % 6); if (i < nd) tot += cw[i]; end
            n = tot - 2 + int'($urandom % 5);
            if (n < 1) n = 1;
            run_case(1'($urandom % 2), nd, cw, n, "random");
        end

        // R6: zero count means 16384 words
        tbl[0] = BUF; tbl[1] = 32'h8000_0000;
        cw = '{0, 0, 0, 0};
        prepare(0, cw, 16384, 1'b1);
        wreg(3'd0, 8'h09);
        wait_end("R6");
        rreg(3'd2, v); check(v == 8'h04, "R6 status after 64 KiB", 32'(v), 32'h04);
        check(wr_a.size() == 16384, "R6 word count", 32'(wr_a.size()), 32'd16384);
        if (wr_a.size() > 0)
            check(wr_a[wr_a.size()-1] == BUF + 32'hFFFC, "R6 last address", wr_a[wr_a.size()-1], BUF + 32'hFFFC);

        // R10: abort while the drive is stalled mid-transfer
        cw = '{8, 0, 0, 0};
        prepare(1, cw, 8, 1'b1);
        dev_stall = 1'b1;
        wreg(3'd0, 8'h09);
        repeat (20) @(negedge clk);
        wreg(3'd0, 8'h00);
        rreg(3'd2, v); check(v == 8'h00, "R10 abort status", 32'(v), 32'h00);
        mreq = 0;
        dev_stall = 1'b0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) mreq++; end
        check(mreq == 0, "R10 no request after abort", 32'(mreq), 0);

        // R12: fault on the second data write
        cw = '{4, 0, 0, 0};
        prepare(1, cw, 4, 1'b1);
        fault_addr = BUF + 32'd4;
        wreg(3'd0, 8'h09);
        wait_end("R12");
        rreg(3'd2, v); check(v == 8'h06 && irq, "R12 fault status", 32'(v), 32'h06);
        check(wr_a.size() == 1, "R12 writes before fault", 32'(wr_a.size()), 32'd1);
        fault_addr = 32'hFFFF_FFFF;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule